// File: doc/BRIEF.md
# Triggered Hit Latency Buffer

This block sits behind a 128-channel binary discriminator. On every clock it writes the full hit vector into a circular store of the most recent 256 samples. A trigger input reaches back into that store by a programmable number of cycles and picks the vector that belongs to the triggered crossing. The vector is queued as an event together with two 12-bit tags: a running count of accepted triggers and a free-running clock count taken at the trigger.

Up to 128 events wait in a queue. A serializer drains them one bit per clock as framed packets, with a qualifying valid output. Sampling, trigger capture and readout all proceed at the same time, so a trigger is never refused because readout is busy. A trigger is lost only when the queue is already full, and that loss raises a sticky flag.

Top module: `hlb_top`

## Requirements
- R1: The hit input is written into the history on every clock after reset. A trigger sampled at clock edge t with stored latency L selects the vector sampled at edge t-L for L from 1 to 255. L = 0 selects the vector from edge t-256.
- R2: If the selected sample lies earlier than the first clock edge after reset (effective latency larger than t, counting edges from 0), the event carries an all-zero hit vector.
- R3: The stored latency takes the value of lat_i only on an edge where lat_load_i is high, and resets to 16. A trigger on the same edge as a load uses the previous value. lat_i has no effect while lat_load_i is low.
- R4: The event tag is a 12-bit count of accepted triggers. It is 0 for the first accepted trigger after reset and wraps modulo 4096.
- R5: The time tag is a 12-bit count of clock edges since reset, taken at the trigger edge (0 at the first edge) and wrapping modulo 4096.
- R6: A packet is 164 bits sent MSB first on ser_o: header 101010101100, event tag, time tag, then hit bit 127 down to hit bit 0. ser_valid_o is high for exactly those 164 consecutive cycles, and ser_o is low whenever ser_valid_o is low.
- R7: With the serializer idle, the first packet bit is on ser_o in the second cycle after the trigger edge. A queued event starts in the cycle right after the previous packet's last bit, with no gap.
- R8: The queue holds 128 events. A trigger arriving while 128 events are held, counted before any removal on the same edge, is dropped, and the event tag does not advance for it.
- R9: ovf_o goes high in the cycle after a dropped trigger and stays high until reset.
- R10: During and right after reset, ser_valid_o, ser_o and ovf_o are low.
- R11: Triggers accepted while packets are being shifted out produce events with correct hits and tags. Capture never pauses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 128 | Binary hit vector, one bit per channel |
| trig_i | input | 1 | Trigger strobe, one event per high cycle |
| lat_i | input | 8 | Latency value to be loaded |
| lat_load_i | input | 1 | Load strobe for the latency register |
| ser_o | output | 1 | Serial packet data, MSB first |
| ser_valid_o | output | 1 | High while a packet bit is on ser_o |
| ovf_o | output | 1 | Sticky flag for a dropped trigger |

## Verification
The bench numbers clock edges from the first edge after reset. Each input is driven in the half cycle before the edge that samples it, so the bench knows the exact edge index of every trigger. From that index it computes the expected hit vector, both tags, and the cycle in which the packet's first bit must show: the edge after the trigger when the serializer is idle, otherwise 164 cycles after the previous packet's load edge. The bench checks that start cycle, the contiguity of the 164 valid cycles and every bit, sampling outputs at falling edges. The overflow flag is expected one cycle after the dropping edge. Queue occupancy is modelled from the same load-edge arithmetic, so the bench knows in advance which trigger must be dropped.

// File: rtl/hlb_pkg.sv
package hlb_pkg;

   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_SEND = 1'b1
   } ser_state_e;

   localparam int unsigned HDR_W = 12;
   localparam logic [HDR_W-1:0] HDR_PATTERN = 12'b1010_1010_1100;

endpackage

// File: rtl/hlb_latency_ring.sv
module hlb_latency_ring #(
   parameter int CH    = 128,
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CH-1:0]    hit_i,
   input  logic [LAT_W-1:0] lat_i,
   output logic [CH-1:0]    sel_o
);
   localparam int DEPTH = 1 << LAT_W;
   localparam logic [LAT_W:0] DEPTH_V = (LAT_W+1)'(DEPTH);

   logic [CH-1:0]    mem [DEPTH];
   logic [LAT_W-1:0] wp;
   logic [LAT_W:0]   fill;
   logic [LAT_W:0]   age;
   logic [LAT_W-1:0] rd_addr;

   // history storage carries no reset; validity is tracked by fill
   always_ff @(posedge clk) begin
      mem[wp] <= hit_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         fill <= '0;
      end else begin
         wp <= wp + 1'b1;
         if (fill != DEPTH_V) fill <= fill + 1'b1;
      end
   end

   // read happens before this edge's write, so latency 0 reaches a full lap back
   always_comb begin
      age     = (lat_i == '0) ? DEPTH_V : {1'b0, lat_i};
      rd_addr = wp - lat_i;
      sel_o   = (age <= fill) ? mem[rd_addr] : '0;
   end

endmodule

// File: rtl/hlb_event_fifo.sv
module hlb_event_fifo #(
   parameter int W     = 152,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_p, rd_p, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full_o  = (cnt == DEPTH_V);
   assign empty_o = (cnt == '0);
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;
   assign dout_o  = mem[rd_p];

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wr_nxt = wr_p + 1'b1;
         assign rd_nxt = rd_p + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_p == AW'(DEPTH-1)) ? '0 : wr_p + 1'b1;
         assign rd_nxt = (rd_p == AW'(DEPTH-1)) ? '0 : rd_p + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p <= '0;
         rd_p <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wr_p <= wr_nxt;
         if (do_pop)  rd_p <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/hlb_serializer.sv
module hlb_serializer import hlb_pkg::*; #(
   parameter int FRAME = 164
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             empty_i,
   input  logic [FRAME-1:0] frame_i,
   output logic             pop_o,
   output logic             ser_o,
   output logic             valid_o
);
   localparam int BW = $clog2(FRAME);
   localparam logic [BW-1:0] LAST = BW'(FRAME - 1);

   ser_state_e       state;
   logic [FRAME-1:0] sh;
   logic [BW-1:0]    bcnt;
   logic             load;

   // a queued event is taken on the edge that ends the current packet
   assign load    = ~empty_i & ((state == SER_IDLE) | (bcnt == LAST));
   assign pop_o   = load;
   assign valid_o = (state == SER_SEND);
   assign ser_o   = sh[FRAME-1] & valid_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SER_IDLE;
         sh    <= '0;
         bcnt  <= '0;
      end else if (load) begin
         state <= SER_SEND;
         sh    <= frame_i;
         bcnt  <= '0;
      end else if (state == SER_SEND) begin
         if (bcnt == LAST) begin
            state <= SER_IDLE;
            sh    <= '0;
            bcnt  <= '0;
         end else begin
            sh   <= {sh[FRAME-2:0], 1'b0};
            bcnt <= bcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hlb_top.sv
module hlb_top import hlb_pkg::*; #(
   parameter int CH        = 128,
   parameter int LAT_W     = 8,
   parameter int EVT_DEPTH = 128,
   parameter int TAG_W     = 12,
   parameter int LAT_RESET = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CH-1:0]    hit_i,
   input  logic             trig_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             lat_load_i,
   output logic             ser_o,
   output logic             ser_valid_o,
   output logic             ovf_o
);
   localparam int ENTRY_W = 2 * TAG_W + CH;
   localparam int FRAME   = int'(HDR_W) + ENTRY_W;

   // elaboration-time parameter checks
   if (CH < 1) begin : g_bad_ch
      $error("hlb_top: CH must be at least 1");
   end
   if (LAT_W < 1 || LAT_W > 12) begin : g_bad_lat
      $error("hlb_top: LAT_W must lie in 1..12");
   end
   if (EVT_DEPTH < 2) begin : g_bad_depth
      $error("hlb_top: EVT_DEPTH must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("hlb_top: TAG_W must be at least 1");
   end
   if (LAT_RESET < 0 || LAT_RESET >= (1 << LAT_W)) begin : g_bad_lrst
      $error("hlb_top: LAT_RESET out of range");
   end

   logic [LAT_W-1:0]   lat_q;
   logic [TAG_W-1:0]   evt_cnt;
   logic [TAG_W-1:0]   time_cnt;
   logic [CH-1:0]      sel_hits;
   logic               fifo_full, fifo_empty, fifo_pop, accept;
   logic [ENTRY_W-1:0] fifo_din, fifo_dout;
   logic [FRAME-1:0]   frame;

   assign accept   = trig_i & ~fifo_full;
   assign fifo_din = {evt_cnt, time_cnt, sel_hits};
   assign frame    = {HDR_PATTERN, fifo_dout};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q    <= LAT_W'(LAT_RESET);
         evt_cnt  <= '0;
         time_cnt <= '0;
         ovf_o    <= 1'b0;
      end else begin
         time_cnt <= time_cnt + 1'b1;
         if (lat_load_i)         lat_q   <= lat_i;
         if (accept)             evt_cnt <= evt_cnt + 1'b1;
         if (trig_i & fifo_full) ovf_o   <= 1'b1;
      end
   end

   hlb_latency_ring #(.CH(CH), .LAT_W(LAT_W)) ring_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (hit_i),
      .lat_i (lat_q),
      .sel_o (sel_hits)
   );

   hlb_event_fifo #(.W(ENTRY_W), .DEPTH(EVT_DEPTH)) fifo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (accept),
      .din_i   (fifo_din),
      .pop_i   (fifo_pop),
      .dout_o  (fifo_dout),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   hlb_serializer #(.FRAME(FRAME)) ser_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .empty_i (fifo_empty),
      .frame_i (frame),
      .pop_o   (fifo_pop),
      .ser_o   (ser_o),
      .valid_o (ser_valid_o)
   );

endmodule

// File: rtl/hlb_chk.sv
module hlb_chk #(
   parameter int FRAME = 164,
   parameter int TAG_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trig_i,
   input logic             ser_o,
   input logic             ser_valid_o,
   input logic             ovf_o,
   input logic             fifo_full,
   input logic [TAG_W-1:0] evt_cnt
);
   localparam int RW = $clog2(FRAME);
   logic [RW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else if (ser_valid_o) run <= (run == RW'(FRAME - 1)) ? '0 : run + 1'b1;
   end

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   // R8
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && fifo_full) |=> (evt_cnt == $past(evt_cnt)));

   // R4
   evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !fifo_full) |=> (evt_cnt == $past(evt_cnt) + 1'b1));

   // R6
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_valid_o |-> !ser_o);

   // R6
   hdr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_valid_o) |-> ser_o);

   // R6
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid_o) |-> (run == '0));

endmodule

bind hlb_top hlb_chk #(.FRAME(FRAME), .TAG_W(TAG_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .trig_i      (trig_i),
   .ser_o       (ser_o),
   .ser_valid_o (ser_valid_o),
   .ovf_o       (ovf_o),
   .fifo_full   (fifo_full),
   .evt_cnt     (evt_cnt)
);

// File: tb/hlb_top_tb_top.sv
`timescale 1ns/1ps
module hlb_top_tb_top;
   localparam int CH        = 128;
   localparam int LAT_W     = 8;
   localparam int EVT_DEPTH = 128;
   localparam int TAG_W     = 12;
   localparam int LAT_RESET = 16;
   localparam int FRAME     = 12 + 2 * TAG_W + CH;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CH-1:0]    hit_i = '0;
   logic             trig_i = 1'b0;
   logic [LAT_W-1:0] lat_i = '0;
   logic             lat_load_i = 1'b0;
   logic             ser_o, ser_valid_o, ovf_o;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   hlb_top #(.CH(CH), .LAT_W(LAT_W), .EVT_DEPTH(EVT_DEPTH), .TAG_W(TAG_W),
             .LAT_RESET(LAT_RESET)) dut_i (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .trig_i(trig_i), .lat_i(lat_i),
      .lat_load_i(lat_load_i), .ser_o(ser_o), .ser_valid_o(ser_valid_o), .ovf_o(ovf_o));

   // scoreboard model state
   logic [CH-1:0]    hist [256];
   logic [FRAME-1:0] exp_q [$];
   int               start_q [$];
   string            tag_q [$];
   int               lat_m  = LAT_RESET;
   int               evt_m  = 0;
   int               nacc   = 0;
   int               npop   = 0;
   int               last_s = -100000;
   int               s_arr [1024];
   int               drops  = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [CH-1:0] rnd_hits();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // driver: drives one cycle's inputs and pushes the expected packet
   task automatic step(input logic [CH-1:0] h, input logic tr,
                       input logic [LAT_W-1:0] lv, input logic ld, input string req);
      @(negedge clk);
      hit_i = h; trig_i = tr; lat_i = lv; lat_load_i = ld;
      if (tr) begin
         int c;
         int eff;
         int s;
         logic [CH-1:0] eh;
         c   = cyc;
         eff = (lat_m == 0) ? 256 : lat_m;
         while (npop < nacc && s_arr[npop] < c) npop++;
         if (nacc - npop >= EVT_DEPTH) begin
            drops++;
         end else begin
            eh = (eff <= c) ? hist[(c - eff) % 256] : '0;
            s  = (c + 1 > last_s + FRAME) ? c + 1 : last_s + FRAME;
            s_arr[nacc] = s;
            nacc++;
            last_s = s;
            exp_q.push_back({12'b1010_1010_1100, evt_m[11:0], c[11:0], eh});
            start_q.push_back(s + 1);
            tag_q.push_back(req);
            evt_m++;
         end
      end
      hist[cyc % 256] = h;
      if (ld) lat_m = int'(lv);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(rnd_hits(), 1'b0, '0, 1'b0, "");
   endtask

   // monitor: collects serial packets and compares with the queue head
   logic [FRAME-1:0] got;
   int               nbits = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_valid_o) begin
            if (nbits == 0) begin
               if (start_q.size() == 0)
                  check(1'b0, "R7", "unexpected packet start", 256'(cyc), 256'(0));
               else
                  check(cyc == start_q[0], "R7", "packet start cycle",
                        256'(cyc), 256'(start_q[0]));
            end
            got = {got[FRAME-2:0], ser_o};
            nbits++;
            if (nbits == FRAME) begin
               if (exp_q.size() != 0) begin
                  check(got == exp_q[0], tag_q[0], "packet content",
                        256'(got), 256'(exp_q[0]));
                  void'(exp_q.pop_front());
                  void'(start_q.pop_front());
                  void'(tag_q.pop_front());
               end
               nbits = 0;
            end
         end else if (nbits != 0) begin
            check(1'b0, "R6", "valid dropped inside packet", 256'(nbits), 256'(FRAME));
            nbits = 0;
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs held low in reset
      check(!ser_valid_o && !ser_o && !ovf_o, "R10", "reset outputs",
            256'({ser_valid_o, ser_o, ovf_o}), 256'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(!ser_valid_o && !ser_o && !ovf_o, "R10", "outputs after reset",
            256'({ser_valid_o, ser_o, ovf_o}), 256'(0));
      // cyc is now 1
      idle(3);                                             // edges 1..3
      step(rnd_hits(), 1'b1, '0, 1'b0, "R2 unfilled ring"); // edge 4, latency 16 > 4
      idle(11);                                            // edges 5..15
      step(rnd_hits(), 1'b1, '0, 1'b0, "R1 R2 boundary");   // edge 16, latency 16 = 16
      idle(20);
      // R3: load and trigger on the same edge uses the old latency
      step(rnd_hits(), 1'b1, 8'd255, 1'b1, "R3 same-edge load");
      idle(280);
      step(rnd_hits(), 1'b1, '0, 1'b0, "R1 latency 255");
      // R3: lat_i without load has no effect
      step(rnd_hits(), 1'b1, 8'd3, 1'b0, "R3 unloaded lat_i ignored");
      step(rnd_hits(), 1'b0, 8'd0, 1'b1, "");
      step(rnd_hits(), 1'b1, '0, 1'b0, "R1 latency 0 is 256");
      step(rnd_hits(), 1'b0, 8'd1, 1'b1, "");
      step(rnd_hits(), 1'b1, '0, 1'b0, "R1 latency 1");
      step(rnd_hits(), 1'b1, '0, 1'b0, "R7 back-to-back");
      idle(2);
      check(!ovf_o, "R9", "no overflow before burst", 256'(ovf_o), 256'(0));
      // R8 R11: burst fills the queue while readout runs
      for (int i = 0; i < 134; i++)
         step(rnd_hits(), 1'b1, '0, 1'b0, "R8 R11 burst");
      step(rnd_hits(), 1'b0, '0, 1'b0, "");
      check(drops > 0, "R8", "model expects drops", 256'(drops), 256'(1));
      check(ovf_o, "R9", "overflow after drop", 256'(ovf_o), 256'(1));
      for (int i = 0; i < 30000 && exp_q.size() != 0; i++) idle(1);
      idle(4);
      check(ovf_o, "R9", "overflow sticky", 256'(ovf_o), 256'(1));
      // R4 R5: tags after the drops and after the time count has wrapped
      step(rnd_hits(), 1'b1, '0, 1'b0, "R4 R5 tag after wrap");
      idle(200);
      check(exp_q.size() == 0, "R6", "all packets delivered",
            256'(exp_q.size()), 256'(0));
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule